// File: doc/BRIEF.md
# Colour RAM Burst Loader

This block holds the 256-word, 16-bit colour table used by a video pixel pipeline and lets a processor fill it through a single write port. Writes to that port are interpreted as a stream. When the port is idle, a write is a header. Its high byte names the first table entry to fill and its low byte says how many colour words follow. Each following write stores one colour word and then moves the destination one entry forward. When the declared count is used up, the port returns to idle and the next write is taken as a new header.

A read of the port gives a status word. The status word shows whether colour words are still expected and how many remain, so software can check that a burst has finished. A separate read-only port lets the pixel pipeline look up a colour by index. The looked-up word appears one clock after the index is presented.

Top module: `cram_burst_port`

## Requirements
- R1: After reset the status word `cpu_rdata` is 0x0000, and the first write is taken as a header.
- R2: An idle-state write is a header: bits 15:8 are the start index and bits 7:0 are the count L. From the next cycle, status bits 15:8 equal L. The header itself writes no table entry.
- R3: Each write while busy stores `cpu_wdata` at the current index, and the index then moves up by one. Consecutive data words therefore fill consecutive entries in order.
- R4: After exactly L data writes the port is idle (status 0x0000), and the next write is decoded as a header.
- R5: The index wraps from 255 to 0 inside a burst.
- R6: A header with L = 0 leaves the port idle with status 0x0000, and the next write is again a header.
- R7: Status bit 0 is 1 exactly while data words remain, bits 15:8 hold the remaining count, and bits 7:1 are always 0. Each data write lowers the count by one.
- R8: `pix_data` shows the table entry at the `pix_idx` sampled on the previous rising clock edge.
- R9: If a pixel read and a data write address the same entry in the same cycle, the pixel port returns the old word, and it returns the new word from the next read on. A data write changes no entry other than the one it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencing state |
| cpu_wr | input | 1 | Write strobe of the processor port |
| cpu_wdata | input | 16 | Header or colour word |
| cpu_rdata | output | 16 | Status word |
| pix_idx | input | 8 | Pixel pipeline colour index |
| pix_data | output | 16 | Colour word, one cycle after the index |

## Verification
A processor data write and a pixel lookup can land on the same table entry in the same cycle. The bench provokes this by sending a one-word header aimed at an entry, then presenting that entry's index on the pixel port in the same cycle as the data write. The read is judged correct when it returns the previous contents in that cycle and the new word on the following read. Full-table sweeps that run across the wrap point confirm that no other entry changed.

// File: rtl/cram_burst_port.sv
module cram_burst_port #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic [AW-1:0] pix_idx,
  output logic [DW-1:0] pix_data
);
  localparam int DEPTH = 1 << AW;
  localparam int HB = DW - AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] left;
  logic          busy;

  wire data_wr = cpu_wr && busy;
  wire hdr_wr  = cpu_wr && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
      wptr <= '0;
    end else if (hdr_wr) begin
      wptr <= cpu_wdata[DW-1 -: AW];
      left <= cpu_wdata[AW-1:0];
      busy <= cpu_wdata[AW-1:0] != '0;
    end else if (data_wr) begin
      wptr <= wptr + 1'b1;
      left <= left - 1'b1;
      busy <= left != AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (data_wr) mem[wptr] <= cpu_wdata;
  end

  always_ff @(posedge clk) pix_data <= mem[pix_idx];

  assign cpu_rdata = {left, {(HB-1){1'b0}}, busy};
endmodule

module cram_burst_port_chk #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_wr,
  input logic [DW-1:0] cpu_wdata,
  input logic [DW-1:0] cpu_rdata
);
  wire          st_busy = cpu_rdata[0];
  wire [AW-1:0] st_left = cpu_rdata[DW-1 -: AW];

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> cpu_rdata == '0);

  p_hdr_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !st_busy) |=> st_left == $past(cpu_wdata[AW-1:0]));

  p_last_word_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && st_busy && st_left == AW'(1)) |=> cpu_rdata == '0);

  p_zero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !st_busy && cpu_wdata[AW-1:0] == '0) |=> !st_busy);

  p_count_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && st_busy) |=> st_left == $past(st_left) - AW'(1));

  p_busy_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_busy == (st_left != '0));

  p_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[DW-AW-1:1] == '0);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr && $past(rst_n)) |=> $stable(cpu_rdata));
endmodule

bind cram_burst_port cram_burst_port_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr),
  .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
);

// File: tb/cram_burst_port_tb.sv
module cram_burst_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic [7:0]  pix_idx = '0;
  logic [15:0] pix_data;

  logic [15:0] model [256];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cram_burst_port dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .pix_idx(pix_idx), .pix_data(pix_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w);
    @(negedge clk);
    cpu_wr = 1'b1;
    cpu_wdata = w;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic burst(input logic [7:0] dst, input logic [7:0] len, input int seed);
    put({dst, len});
    for (int i = 0; i < len; i++) begin
      logic [15:0] v;
      v = 16'((seed * 257 + i * 40503) ^ (i << 3));
      model[8'(dst + i)] = v;
      put(v);
    end
  endtask

  task automatic look(input logic [7:0] a, input string tag);
    @(negedge clk);
    pix_idx = a;
    @(negedge clk);
    chk(pix_data === model[a], tag, pix_data, model[a]);
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 256; a++) look(8'(a), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk(cpu_rdata === 16'h0000, "R1 reset status", cpu_rdata, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_rdata === 16'h0000, "R1 idle after reset", cpu_rdata, 16'h0000);

    // R3 R5: long burst that crosses 255 -> 0, plus the one entry it missed
    put(16'h10FF);
    chk(cpu_rdata === 16'hFF01, "R2 header status", cpu_rdata, 16'hFF01);
    for (int i = 0; i < 255; i++) begin
      logic [15:0] v;
      v = 16'(i * 613 + 7);
      model[8'(8'h10 + i)] = v;
      put(v);
      if (i == 99)
        chk(cpu_rdata === 16'h9B01, "R7 mid-burst count", cpu_rdata, 16'h9B01);
    end
    chk(cpu_rdata === 16'h0000, "R4 idle after burst", cpu_rdata, 16'h0000);
    burst(8'h0F, 8'd1, 3);
    sweep("R3 R5 full table");

    // R6: zero-length header, next write is header again
    put(16'h0500);
    chk(cpu_rdata === 16'h0000, "R6 zero length idle", cpu_rdata, 16'h0000);
    burst(8'h07, 8'd2, 11);
    look(8'h05, "R6 entry 05 untouched");
    look(8'h07, "R6 entry 07");
    look(8'h08, "R6 entry 08");

    // R2: header writes no entry (header value would be visible if stored)
    put(16'h3303);
    chk(cpu_rdata === 16'h0301, "R2 header count", cpu_rdata, 16'h0301);
    look(8'h33, "R2 header stores nothing");
    look(8'h34, "R2 header stores nothing");
    for (int i = 0; i < 3; i++) begin
      model[8'(8'h33 + i)] = 16'hA000 + 16'(i);
      put(16'hA000 + 16'(i));
    end
    chk(cpu_rdata === 16'h0000, "R4 idle after 3", cpu_rdata, 16'h0000);
    put(16'h4001);
    chk(cpu_rdata === 16'h0101, "R4 next write is header", cpu_rdata, 16'h0101);
    model[8'h40] = 16'h5A5A;
    put(16'h5A5A);

    // R9: same-cycle write and pixel read of one entry
    for (int k = 0; k < 8; k++) begin
      logic [7:0]  a;
      logic [15:0] old, nw;
      a = 8'(k * 37 + 1);
      old = model[a];
      nw = 16'(16'hC3C3 ^ (k * 4099));
      put({a, 8'h01});
      @(negedge clk);
      pix_idx = a;
      cpu_wr = 1'b1;
      cpu_wdata = nw;
      @(negedge clk);
      cpu_wr = 1'b0;
      chk(pix_data === old, "R9 collision returns old", pix_data, old);
      model[a] = nw;
      @(negedge clk);
      chk(pix_data === nw, "R9 new word next read", pix_data, nw);
      chk(cpu_rdata === 16'h0000, "R4 idle after collision", cpu_rdata, 16'h0000);
    end

    // R8: one-cycle latency with index changing every cycle
    for (int i = 0; i < 16; i++) begin
      logic [7:0] a;
      a = 8'(i * 29);
      @(negedge clk);
      pix_idx = a;
      @(posedge clk);
      @(negedge clk);
      chk(pix_data === model[a], "R8 latency", pix_data, model[a]);
    end

    burst(8'hF0, 8'h20, 21);
    sweep("R9 R5 table after wrap burst");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule